// File: doc/BRIEF.md
# Receive Destination Address Filter

This block judges each incoming Ethernet frame by its 48-bit destination address and reports whether the frame should be kept. The receive MAC streams the six destination bytes into it, lowest-order byte first, one byte for each cycle in which the byte-valid input is high. A start-of-frame strobe marks the first byte. One cycle after the sixth byte the block raises a one-cycle done pulse. In that same cycle it presents an accept flag and a two-bit code that says why the frame was accepted or rejected.

The address is compared against a programmed station address and is also tested for the all-ones broadcast pattern. Three mode bits are applied on top of that compare. Promiscuous mode accepts everything. Broadcast rejection can be turned on by itself. Matching on the station address can be switched off entirely. A separate level input admits every group (multicast) address. The mode bits can only be changed while the controller reports that it is halted (stopped or suspended). A software reset turns broadcast rejection off again but leaves the other two mode bits as they were.

Top module: `rx_da_filter`

## Requirements
- R1: While `rst` is high and after it is released, `done`=0, `accept`=0 and `match_type`=00, and all three mode bits are 0, so a broadcast frame is accepted with code 10 before any mode write.
- R2: The first byte comes with `sof`=1 and `byte_vld`=1. Byte k (k=0..5) is address bits [8k+7:8k]. `byte_vld` may drop between bytes. `done` is high for exactly one cycle, in the cycle after the sixth valid byte, and it is low at every other time.
- R3: A destination with bit 0 = 0 that equals `station_addr` is accepted with `match_type`=01 when promiscuous is off and station matching is enabled.
- R4: The all-ones destination is accepted with code 10 while broadcast rejection is off. It is rejected with code 00 while broadcast rejection is on and promiscuous is off.
- R5: While promiscuous mode is on, every frame is accepted with code 11, whatever its destination.
- R6: While station matching is disabled and promiscuous is off, a destination equal to the station address is rejected with code 00.
- R7: A group destination (bit 0 of the first byte = 1, not all ones) is accepted with code 11 when `mcast_all`=1 in the final byte's cycle, and rejected with code 00 when it is 0 (promiscuous off).
- R8: An individual destination that differs from the station address in any byte is rejected with code 00 (promiscuous off).
- R9: A mode write (`mode_wr`=1) loads `wr_promisc`, `wr_bcast_off` and `wr_phys_off` only when `ctrl_halted`=1 in the same cycle. Otherwise it is ignored and the filtering of later frames does not change.
- R10: A `soft_rst` pulse clears broadcast rejection, and it wins over a mode write in the same cycle. Promiscuous and station-disable keep their values.
- R11: A `sof` byte that arrives while a frame is still being collected drops the earlier frame. That frame gets no decision, and collection starts over with this byte as byte 0.
- R12: `accept` is 1 exactly when `match_type` is not 00. Both hold their values between done pulses. Valid bytes that arrive outside a frame (no `sof` after a decision) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| soft_rst | input | 1 | Software reset pulse; clears broadcast rejection |
| ctrl_halted | input | 1 | Controller is stopped or suspended; mode writes allowed |
| mode_wr | input | 1 | Mode write strobe |
| wr_promisc | input | 1 | Promiscuous value to write |
| wr_bcast_off | input | 1 | Broadcast-rejection value to write |
| wr_phys_off | input | 1 | Station-match-disable value to write |
| mcast_all | input | 1 | Accept every group address |
| station_addr | input | 48 | Station address, byte k in bits [8k+7:8k] |
| sof | input | 1 | Start of frame, with the first byte |
| byte_vld | input | 1 | Destination byte valid |
| byte_data | input | 8 | Destination byte |
| done | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Frame accepted |
| match_type | output | 2 | 00 reject, 01 station, 10 broadcast, 11 promiscuous/group |

## Verification
Each decision is due one clock after the edge that takes the sixth byte. The bench drives on falling edges, so it samples `done`, `accept` and `match_type` at the falling edge right after that sixth byte. At every earlier falling edge of the frame it expects `done` low. A mode write or soft reset goes in one cycle before a frame begins, and its effect is judged only from the verdict on the following frame. After each verdict the bench checks at the next falling edge that `done` has dropped and that the verdict is unchanged. Stray bytes and aborted frames are checked at the same half-cycle points.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        MT_REJECT  = 2'b00,
        MT_STATION = 2'b01,
        MT_BCAST   = 2'b10,
        MT_OTHER   = 2'b11
    } match_t;

    typedef struct packed {
        logic promisc;
        logic bcast_off;
        logic phys_off;
    } mode_t;

    typedef struct packed {
        logic sta_hit;
        logic all_ones;
        logic group;
    } cls_t;

    function automatic match_t classify(cls_t c, mode_t m, logic mc_all);
        match_t r;
        if (m.promisc)
            r = MT_OTHER;
        else if (c.all_ones)
            r = m.bcast_off ? MT_REJECT : MT_BCAST;
        else if (c.group)
            r = mc_all ? MT_OTHER : MT_REJECT;
        else if (c.sta_hit && !m.phys_off)
            r = MT_STATION;
        else
            r = MT_REJECT;
        return r;
    endfunction

endpackage

// File: rtl/rxf_mode_regs.sv
module rxf_mode_regs
    import rxf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  soft_rst,
    input  logic  ctrl_halted,
    input  logic  mode_wr,
    input  mode_t wr_mode,
    output mode_t mode_q
);
    mode_t mode_d;

    always_comb begin
        mode_d = mode_q;
        if (mode_wr && ctrl_halted)
            mode_d = wr_mode;
        if (soft_rst)
            mode_d.bcast_off = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else
            mode_q <= mode_d;
    end

    assert_wr_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(ctrl_halted) && !$past(soft_rst) && !$past(rst)) |-> $stable(mode_q));

    assert_soft_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $past(soft_rst) |-> (!mode_q.bcast_off
                             && mode_q.promisc == $past(mode_d.promisc)));

endmodule

// File: rtl/rxf_collect.sv
module rxf_collect
    import rxf_pkg::*;
#(
    parameter int BYTES = 6,
    parameter int BW    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                byte_vld,
    input  logic                sof,
    input  logic [BW-1:0]       byte_data,
    input  logic [BYTES*BW-1:0] station_addr,
    output logic                fin,
    output cls_t                cls
);
    localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES - 1);

    logic             active;
    logic [IDX_W-1:0] cnt;
    logic             sta_run_q, ones_run_q, group_q;

    logic [BYTES-1:0] lane_eq;
    logic             take, first;
    logic [IDX_W-1:0] pos;
    logic             sta_run, ones_run;

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign lane_eq[i] = (byte_data == station_addr[i*BW +: BW]);
    end

    always_comb begin
        first    = byte_vld && sof;
        take     = byte_vld && (sof || active);
        pos      = first ? '0 : cnt;
        sta_run  = first ? 1'b1 : sta_run_q;
        ones_run = first ? 1'b1 : ones_run_q;
        cls.sta_hit  = sta_run && lane_eq[pos];
        cls.all_ones = ones_run && (&byte_data);
        cls.group    = first ? byte_data[0] : group_q;
        fin          = take && (pos == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            cnt        <= '0;
            sta_run_q  <= 1'b0;
            ones_run_q <= 1'b0;
            group_q    <= 1'b0;
        end else if (take) begin
            active     <= !fin;
            cnt        <= fin ? '0 : pos + IDX_W'(1);
            sta_run_q  <= cls.sta_hit;
            ones_run_q <= cls.all_ones;
            group_q    <= cls.group;
        end
    end

    assert_pos_range_R2: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt != '0 && cnt <= LAST));

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fin,
    input  cls_t   cls,
    input  mode_t  mode,
    input  logic   mc_all,
    output logic   done,
    output logic   accept,
    output match_t mtype
);
    match_t verdict;

    always_comb verdict = classify(cls, mode, mc_all);

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            accept <= 1'b0;
            mtype  <= MT_REJECT;
        end else begin
            done <= fin;
            if (fin) begin
                accept <= (verdict != MT_REJECT);
                mtype  <= verdict;
            end
        end
    end

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int BYTE_W     = 8,
    localparam int ADDR_W    = ADDR_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              ctrl_halted,
    input  logic              mode_wr,
    input  logic              wr_promisc,
    input  logic              wr_bcast_off,
    input  logic              wr_phys_off,
    input  logic              mcast_all,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              sof,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              done,
    output logic              accept,
    output logic [1:0]        match_type
);
    mode_t  wr_mode, mode_q;
    cls_t   cls;
    logic   fin;
    match_t mtype;

    assign wr_mode    = '{promisc: wr_promisc, bcast_off: wr_bcast_off, phys_off: wr_phys_off};
    assign match_type = mtype;

    rxf_mode_regs u_mode (
        .clk         (clk),
        .rst         (rst),
        .soft_rst    (soft_rst),
        .ctrl_halted (ctrl_halted),
        .mode_wr     (mode_wr),
        .wr_mode     (wr_mode),
        .mode_q      (mode_q)
    );

    rxf_collect #(.BYTES(ADDR_BYTES), .BW(BYTE_W)) u_collect (
        .clk          (clk),
        .rst          (rst),
        .byte_vld     (byte_vld),
        .sof          (sof),
        .byte_data    (byte_data),
        .station_addr (station_addr),
        .fin          (fin),
        .cls          (cls)
    );

    rxf_decide u_decide (
        .clk    (clk),
        .rst    (rst),
        .fin    (fin),
        .cls    (cls),
        .mode   (mode_q),
        .mc_all (mcast_all),
        .done   (done),
        .accept (accept),
        .mtype  (mtype)
    );

    assert_done_after_byte_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(byte_vld) |-> !done);

    assert_promisc_code_R5: assert property (@(posedge clk) disable iff (rst)
        (done && $past(mode_q.promisc)) |-> (match_type == 2'b11 && accept));

    assert_bcast_block_R4: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(mode_q.promisc) && $past(mode_q.bcast_off)) |-> (match_type != 2'b10));

    assert_phys_block_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(mode_q.promisc) && $past(mode_q.phys_off)) |-> (match_type != 2'b01));

    assert_accept_code_R12: assert property (@(posedge clk) disable iff (rst)
        accept == (match_type != 2'b00));

endmodule

// File: tb/tb_rx_da_filter.sv
`timescale 1ns/1ps
module tb_rx_da_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        ctrl_halted = 1'b0;
    logic        mode_wr = 1'b0;
    logic        wr_promisc = 1'b0, wr_bcast_off = 1'b0, wr_phys_off = 1'b0;
    logic        mcast_all = 1'b0;
    logic [47:0] station_addr = 48'h0;
    logic        sof = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = 8'h0;
    logic        done, accept;
    logic [1:0]  match_type;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit m_pro = 0, m_bco = 0, m_pho = 0;

    always #2.5 clk = ~clk;

    rx_da_filter dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .ctrl_halted(ctrl_halted),
        .mode_wr(mode_wr), .wr_promisc(wr_promisc), .wr_bcast_off(wr_bcast_off),
        .wr_phys_off(wr_phys_off), .mcast_all(mcast_all), .station_addr(station_addr),
        .sof(sof), .byte_vld(byte_vld), .byte_data(byte_data),
        .done(done), .accept(accept), .match_type(match_type)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(logic [47:0] a, bit mca);
        if (m_pro) return 2'b11;
        if (&a) return m_bco ? 2'b00 : 2'b10;
        if (a[0]) return mca ? 2'b11 : 2'b00;
        if (a == station_addr && !m_pho) return 2'b01;
        return 2'b00;
    endfunction

    task automatic write_mode(input bit p, input bit b, input bit s, input bit halted);
        @(negedge clk);
        mode_wr = 1; wr_promisc = p; wr_bcast_off = b; wr_phys_off = s; ctrl_halted = halted;
        @(negedge clk);
        mode_wr = 0; ctrl_halted = 0;
        if (halted) begin m_pro = p; m_bco = b; m_pho = s; end
    endtask

    task automatic pulse_soft();
        @(negedge clk); soft_rst = 1;
        @(negedge clk); soft_rst = 0;
        m_bco = 0;
    endtask

    // drive n bytes of a starting a frame (n<6 gives an unfinished frame)
    task automatic drive_bytes(input logic [47:0] a, input int n, input bit gaps, input string req);
        for (int i = 0; i < n; i++) begin
            if (gaps && i > 0 && ($urandom % 3 == 0)) begin
                @(negedge clk);
                chk(done == 1'b0, req, done, 0);
                byte_vld = 0; sof = 0;
            end
            @(negedge clk);
            if (i > 0) chk(done == 1'b0, req, done, 0);
            byte_vld = 1; sof = (i == 0); byte_data = a[8*i +: 8];
        end
    endtask

    task automatic send_frame(input logic [47:0] a, input bit gaps, input string req);
        logic [1:0] e;
        e = exp_code(a, mcast_all);
        drive_bytes(a, 6, gaps, req);
        @(negedge clk);
        byte_vld = 0; sof = 0;
        chk(done == 1'b1, {req, " done"}, done, 1);
        chk(match_type == e && accept == (e != 2'b00), req, {accept, match_type}, {e != 2'b00, e});
        @(negedge clk);
        chk(done == 1'b0 && match_type == e && accept == (e != 2'b00), "R12 hold",
            {done, accept, match_type}, {1'b0, e != 2'b00, e});
    endtask

    function automatic logic [47:0] rnd48();
        return {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
    endfunction

    initial begin
        void'($urandom(32'd7341));
        station_addr = rnd48() & ~48'h1;
        repeat (3) @(negedge clk);
        chk(done == 0 && accept == 0 && match_type == 0, "R1 reset", {done, accept, match_type}, 0);
        rst = 0;
        @(negedge clk);
        chk(done == 0 && accept == 0 && match_type == 0, "R1 after release", {done, accept, match_type}, 0);

        send_frame(48'hFFFF_FFFF_FFFF, 0, "R1 default broadcast");
        send_frame(station_addr, 0, "R3 station");
        send_frame(station_addr, 1, "R2 gaps station");
        send_frame(station_addr ^ 48'h0000_0100_0000, 0, "R8 one byte off");
        send_frame(48'h1234_5678_9AB0, 0, "R8 unicast");
        mcast_all = 0; send_frame(48'h0000_0000_0001, 0, "R7 group reject");
        mcast_all = 1; send_frame(48'h5E00_0000_0001, 0, "R7 group accept");
        mcast_all = 0;

        write_mode(0, 1, 0, 1);
        send_frame(48'hFFFF_FFFF_FFFF, 0, "R4 broadcast off");
        write_mode(0, 0, 0, 0); // ignored: not halted
        send_frame(48'hFFFF_FFFF_FFFF, 0, "R9 ignored write");
        write_mode(0, 1, 1, 1);
        send_frame(station_addr, 0, "R6 station disabled");
        write_mode(1, 1, 1, 1);
        send_frame(48'hFFFF_FFFF_FFFF, 0, "R5 promisc broadcast");
        send_frame(48'h0102_0304_0506, 0, "R5 promisc unicast");
        pulse_soft();
        send_frame(48'hFFFF_FFFF_FFFF, 0, "R10 promisc kept");
        write_mode(0, 1, 1, 1);
        pulse_soft();
        send_frame(48'hFFFF_FFFF_FFFF, 0, "R10 broadcast restored");
        send_frame(station_addr, 0, "R10 phys_off kept");
        write_mode(0, 0, 0, 1);

        // R11: aborted frame, then a new one
        drive_bytes(station_addr, 3, 0, "R11 partial");
        send_frame(48'h0A0B_0C0D_0E00, 0, "R11 restart");

        // R12: stray bytes without sof are ignored
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(done == 0 && match_type == 2'b00, "R12 stray", {done, match_type}, 0);
            byte_vld = 1; sof = 0; byte_data = station_addr[8*(i%6) +: 8];
        end
        @(negedge clk); byte_vld = 0;
        chk(done == 0 && match_type == 2'b00, "R12 stray end", {done, match_type}, 0);

        // constrained random mix
        for (int it = 0; it < 300; it++) begin
            logic [47:0] a;
            int k;
            if ($urandom % 8 == 0)
                write_mode($urandom % 4 == 0, $urandom % 2 == 1, $urandom % 2 == 1, $urandom % 2 == 1);
            if ($urandom % 16 == 0) pulse_soft();
            if ($urandom % 20 == 0) drive_bytes(rnd48(), 1 + $urandom % 5, 0, "R11 random abort");
            mcast_all = $urandom % 2 == 1;
            k = $urandom % 5;
            case (k)
                0: a = station_addr;
                1: a = 48'hFFFF_FFFF_FFFF;
                2: a = rnd48() & ~48'h1;
                3: a = rnd48() | 48'h1;
                default: a = station_addr ^ (48'hFF << (8 * ($urandom % 6)));
            endcase
            send_frame(a, $urandom % 2 == 1, "R3-mix random frame R2");
        end
        summary();
    end

endmodule